// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This block decides, for one conditional relative jump per request, whether the jump is taken, and produces the program counter that fetch should use next. The request supplies a 5-bit condition code, the six status flags (negative, zero, carry, overflow, sticky overflow-trap, sticky bit), the program counter already advanced past the branch, a signed 8-bit displacement, an 8-bit register with a 3-bit bit index for the bit-test forms, and an 8-bit loop count for the decrement-and-branch form.

One cycle after a request the block presents its decision, the next program counter, a one-cycle strobe that tells the flag logic to clear the sticky overflow-trap flag, and, for the loop form, the decremented count together with a write-back strobe. Flag generation, instruction fetch and the register file lie outside the block; a request with `valid_i` low leaves the next-PC and count outputs holding and drops every strobe.

Condition codes: 0 N set, 1 N clear, 2 N and Z clear, 3 N or Z set, 4 Z set, 5 Z clear, 6 C set, 7 C clear, 8 C set and Z clear, 9 C clear or Z set, 10 V set, 11 V clear, 12 VT set (and clear it), 13 VT clear, 14 ST set, 15 ST clear, 16 selected bit 1, 17 selected bit 0, 18 decrement and branch on nonzero, 19 to 31 reserved.

Top module: `cbe_branch_unit`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `taken_o`, `vt_clr_o` and `count_we_o` are 0 and `next_pc_o` and `count_o` are 0.
- R2: `done_o` is 1 exactly in the cycle after a cycle with `valid_i` high; `taken_o`, `vt_clr_o` and `count_we_o` are 0 whenever `done_o` is 0, and `next_pc_o`/`count_o` hold their values.
- R3: Signed-compare codes: 0 takes on N=1, 1 on N=0, 2 on N=0 and Z=0, 3 on N=1 or Z=1, 4 on Z=1, 5 on Z=0.
- R4: Unsigned-compare codes: 6 takes on C=1, 7 on C=0, 8 on C=1 and Z=0, 9 on C=0 or Z=1.
- R5: Flag-test codes: 10 takes on V=1, 11 on V=0, 12 on VT=1, 13 on VT=0, 14 on ST=1, 15 on ST=0.
- R6: `vt_clr_o` pulses with the result exactly when code 12 is taken, and never otherwise.
- R7: Code 16 takes when bit `bit_sel_i` of `test_reg_i` is 1; code 17 takes when it is 0.
- R8: Code 18 drives `count_o` to `count_i` minus 1 modulo 256 with `count_we_o` high, and takes when that result is nonzero; a start value of 0 yields FFH and is taken, a start value of 1 yields 0 and is not taken. Other codes leave `count_we_o` low.
- R9: A taken branch gives `next_pc_o` = `pc_i` + sign-extended `offset_i` modulo 65536; a branch not taken gives `next_pc_o` = `pc_i`.
- R10: Codes 19 to 31 are never taken and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| cond_i | input | 5 | Condition code |
| n_i | input | 1 | Negative flag |
| z_i | input | 1 | Zero flag |
| c_i | input | 1 | Carry flag |
| v_i | input | 1 | Overflow flag |
| vt_i | input | 1 | Sticky overflow-trap flag |
| st_i | input | 1 | Sticky bit flag |
| pc_i | input | 16 | PC after the branch instruction |
| offset_i | input | 8 | Signed displacement |
| test_reg_i | input | 8 | Register for bit-test codes |
| bit_sel_i | input | 3 | Bit index for bit-test codes |
| count_i | input | 8 | Loop count for code 18 |
| done_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| vt_clr_o | output | 1 | Clear strobe for the sticky overflow-trap flag |
| count_o | output | 8 | Decremented loop count |
| count_we_o | output | 1 | Write-back strobe for `count_o` |

## Verification
The only state is the result register, so a wrong decode or a stale capture shows at the ports one cycle after the offending request: a wrong `taken_o`, a `next_pc_o` that is off by the displacement, or a strobe on the wrong code. A result register that fails to hold during idle cycles shows as a changed `next_pc_o` or `count_o` in the first idle cycle. The reference model in the bench checks every output on every cycle, so no fault can stay hidden past the next edge.

// File: rtl/cbe_pkg.sv
package cbe_pkg;
  typedef enum logic [4:0] {
    CC_LT   = 5'd0,
    CC_GE   = 5'd1,
    CC_GT   = 5'd2,
    CC_LE   = 5'd3,
    CC_EQ   = 5'd4,
    CC_NE   = 5'd5,
    CC_C    = 5'd6,
    CC_NC   = 5'd7,
    CC_H    = 5'd8,
    CC_NH   = 5'd9,
    CC_V    = 5'd10,
    CC_NV   = 5'd11,
    CC_VT   = 5'd12,
    CC_NVT  = 5'd13,
    CC_ST   = 5'd14,
    CC_NST  = 5'd15,
    CC_BS   = 5'd16,
    CC_BC   = 5'd17,
    CC_DJNZ = 5'd18
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic vt;
    logic st;
  } flags_t;
endpackage

// File: rtl/cbe_cond_eval.sv
module cbe_cond_eval
  import cbe_pkg::*;
(
  input  logic [4:0] cond_i,
  input  flags_t     flags_i,
  input  logic       bit_val_i,
  input  logic       cnt_nz_i,
  output logic       taken_o,
  output logic       vt_clr_o,
  output logic       is_loop_o
);
  always_comb begin
    taken_o   = 1'b0;
    vt_clr_o  = 1'b0;
    is_loop_o = 1'b0;
    case (cond_i)
      CC_LT:   taken_o = flags_i.n;
      CC_GE:   taken_o = ~flags_i.n;
      CC_GT:   taken_o = ~flags_i.n & ~flags_i.z;
      CC_LE:   taken_o = flags_i.n | flags_i.z;
      CC_EQ:   taken_o = flags_i.z;
      CC_NE:   taken_o = ~flags_i.z;
      CC_C:    taken_o = flags_i.c;
      CC_NC:   taken_o = ~flags_i.c;
      CC_H:    taken_o = flags_i.c & ~flags_i.z;
      CC_NH:   taken_o = ~flags_i.c | flags_i.z;
      CC_V:    taken_o = flags_i.v;
      CC_NV:   taken_o = ~flags_i.v;
      CC_VT: begin
        taken_o  = flags_i.vt;
        vt_clr_o = flags_i.vt;
      end
      CC_NVT:  taken_o = ~flags_i.vt;
      CC_ST:   taken_o = flags_i.st;
      CC_NST:  taken_o = ~flags_i.st;
      CC_BS:   taken_o = bit_val_i;
      CC_BC:   taken_o = ~bit_val_i;
      CC_DJNZ: begin
        taken_o   = cnt_nz_i;
        is_loop_o = 1'b1;
      end
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbe_bit_pick.sv
module cbe_bit_pick #(
  parameter int REG_W = 8,
  localparam int SEL_W = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic [REG_W-1:0] reg_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < REG_W; i++) begin
      if (sel_i == SEL_W'(i)) bit_o = reg_i[i];
    end
  end
endmodule

// File: rtl/cbe_loop_dec.sv
module cbe_loop_dec #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nz_o
);
  assign cnt_o = cnt_i - CNT_W'(1);
  assign nz_o  = |cnt_o;
endmodule

// File: rtl/cbe_target.sv
module cbe_target #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 8,
  localparam int EXT_W = PC_W - OFS_W
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             take_i,
  output logic [PC_W-1:0]  next_o
);
  logic [PC_W-1:0] ofs_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
    end else begin : g_trunc
      assign ofs_ext = ofs_i[PC_W-1:0];
    end
  endgenerate

  assign next_o = take_i ? (pc_i + ofs_ext) : pc_i;
endmodule

// File: rtl/cbe_branch_unit.sv
module cbe_branch_unit
  import cbe_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 8,
  parameter int REG_W = 8,
  parameter int CNT_W = 8,
  localparam int SEL_W = (REG_W > 1) ? $clog2(REG_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [4:0]       cond_i,
  input  logic             n_i,
  input  logic             z_i,
  input  logic             c_i,
  input  logic             v_i,
  input  logic             vt_i,
  input  logic             st_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] offset_i,
  input  logic [REG_W-1:0] test_reg_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             done_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             vt_clr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             count_we_o
);
  flags_t            flags;
  logic              bit_val;
  logic [CNT_W-1:0]  cnt_dec;
  logic              cnt_nz;
  logic              take;
  logic              vt_clr;
  logic              is_loop;
  logic [PC_W-1:0]   target;

  assign flags = '{n: n_i, z: z_i, c: c_i, v: v_i, vt: vt_i, st: st_i};

  cbe_bit_pick #(.REG_W(REG_W)) u_bit (
    .reg_i (test_reg_i),
    .sel_i (bit_sel_i),
    .bit_o (bit_val)
  );

  cbe_loop_dec #(.CNT_W(CNT_W)) u_dec (
    .cnt_i (count_i),
    .cnt_o (cnt_dec),
    .nz_o  (cnt_nz)
  );

  cbe_cond_eval u_eval (
    .cond_i    (cond_i),
    .flags_i   (flags),
    .bit_val_i (bit_val),
    .cnt_nz_i  (cnt_nz),
    .taken_o   (take),
    .vt_clr_o  (vt_clr),
    .is_loop_o (is_loop)
  );

  cbe_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
    .pc_i   (pc_i),
    .ofs_i  (offset_i),
    .take_i (take),
    .next_o (target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      taken_o    <= 1'b0;
      vt_clr_o   <= 1'b0;
      count_we_o <= 1'b0;
      next_pc_o  <= '0;
      count_o    <= '0;
    end else begin
      done_o     <= valid_i;
      taken_o    <= valid_i & take;
      vt_clr_o   <= valid_i & vt_clr;
      count_we_o <= valid_i & is_loop;
      if (valid_i) next_pc_o <= target;
      if (valid_i && is_loop) count_o <= cnt_dec;
    end
  end
endmodule

// File: rtl/cbe_branch_unit_chk.sv
module cbe_branch_unit_chk #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             done_o,
  input logic             taken_o,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             vt_clr_o,
  input logic [CNT_W-1:0] count_o,
  input logic             count_we_o
);
  p_done_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !taken_o && !vt_clr_o && !count_we_o);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(next_pc_o) && $stable(count_o));
  p_clear_on_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vt_clr_o |-> taken_o);
  p_loop_nz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_we_o |-> (taken_o == (count_o != '0)));
  p_fallthrough_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i ##1 (done_o && !taken_o) |-> next_pc_o == $past(pc_i));
endmodule

bind cbe_branch_unit cbe_branch_unit_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .pc_i       (pc_i),
  .done_o     (done_o),
  .taken_o    (taken_o),
  .next_pc_o  (next_pc_o),
  .vt_clr_o   (vt_clr_o),
  .count_o    (count_o),
  .count_we_o (count_we_o)
);

// File: tb/sim_cbe_branch_unit.sv
`timescale 1ns/1ps
module sim_cbe_branch_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  cond_i = '0;
  logic        n_i = 0, z_i = 0, c_i = 0, v_i = 0, vt_i = 0, st_i = 0;
  logic [15:0] pc_i = '0;
  logic [7:0]  offset_i = '0;
  logic [7:0]  test_reg_i = '0;
  logic [2:0]  bit_sel_i = '0;
  logic [7:0]  count_i = '0;
  logic        done_o, taken_o, vt_clr_o, count_we_o;
  logic [15:0] next_pc_o;
  logic [7:0]  count_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected outputs after the next edge
  bit       e_done, e_taken, e_vclr, e_we;
  int       e_pc, e_cnt;

  always #10 clk_i = ~clk_i;

  cbe_branch_unit u0 (
    .clk_i, .rst_ni, .valid_i, .cond_i, .n_i, .z_i, .c_i, .v_i, .vt_i, .st_i,
    .pc_i, .offset_i, .test_reg_i, .bit_sel_i, .count_i,
    .done_o, .taken_o, .next_pc_o, .vt_clr_o, .count_o, .count_we_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string cond_req(int cc);
    if (cc <= 5) return "R3";
    if (cc <= 9) return "R4";
    if (cc <= 15) return "R5";
    if (cc <= 17) return "R7";
    if (cc == 18) return "R8";
    return "R10";
  endfunction

  function automatic bit model_take(int cc, bit n, bit z, bit c, bit v, bit vt,
                                    bit st, bit b, int cnt);
    case (cc)
      0: return n;
      1: return !n;
      2: return !n && !z;
      3: return n || z;
      4: return z;
      5: return !z;
      6: return c;
      7: return !c;
      8: return c && !z;
      9: return !c || z;
      10: return v;
      11: return !v;
      12: return vt;
      13: return !vt;
      14: return st;
      15: return !st;
      16: return b;
      17: return !b;
      18: return ((cnt + 255) % 256) != 0;
      default: return 0;
    endcase
  endfunction

  task automatic step(bit vld, int cc, bit [5:0] f, int pc, int ofs,
                      int rg, int sel, int cnt);
    int sofs;
    bit t;
    valid_i = vld; cond_i = 5'(cc);
    {n_i, z_i, c_i, v_i, vt_i, st_i} = f;
    pc_i = 16'(pc); offset_i = 8'(ofs); test_reg_i = 8'(rg);
    bit_sel_i = 3'(sel); count_i = 8'(cnt);
    e_done = vld;
    if (vld) begin
      t = model_take(cc, f[5], f[4], f[3], f[2], f[1], f[0], rg[sel], cnt);
      sofs = (ofs > 127) ? ofs - 256 : ofs;
      e_taken = t;
      e_vclr = t && cc == 12;
      e_we = cc == 18;
      e_pc = t ? ((pc + sofs + 65536) % 65536) : pc;
      if (cc == 18) e_cnt = (cnt + 255) % 256;
    end else begin
      e_taken = 0; e_vclr = 0; e_we = 0;
    end
    @(negedge clk_i);
    chk("R2 done", done_o, e_done);
    chk({cond_req(cc), " taken"}, taken_o, e_taken);
    chk(vld ? "R9 next_pc" : "R2 hold pc", next_pc_o, e_pc);
    chk("R6 vt_clr", vt_clr_o, e_vclr);
    chk("R8 count_we", count_we_o, e_we);
    chk("R8 count", count_o, e_cnt);
  endtask

  initial begin
    e_pc = 0; e_cnt = 0;
    #25;
    // R1 reset state
    chk("R1 done", done_o, 0);
    chk("R1 taken", taken_o, 0);
    chk("R1 vt_clr", vt_clr_o, 0);
    chk("R1 count_we", count_we_o, 0);
    chk("R1 next_pc", next_pc_o, 0);
    chk("R1 count", count_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3 R4 R5 R10: every code against every flag pattern
    for (int cc = 0; cc < 32; cc++)
      for (int f = 0; f < 64; f++)
        step(1, cc, 6'(f), 16'h1000 + cc * 64 + f, (f * 37) % 256, 8'h5A, f % 8, 9);
    // R2 idle cycles hold outputs
    step(0, 12, 6'h3F, 16'h2222, 8'h10, 0, 0, 5);
    step(0, 18, 6'h00, 16'h3333, 8'h10, 0, 0, 1);
    // R7 bit-test sweep
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 8; s++) begin
        step(1, 16, 6'h00, 16'h4000, 8'h08, 8'hA5 ^ (r * 8'h33), s, 0);
        step(1, 17, 6'h3F, 16'h4000, 8'hF8, 8'hA5 ^ (r * 8'h33), s, 0);
      end
    // R8 loop count corners
    step(1, 18, 6'h00, 16'h5000, 8'hFE, 0, 0, 8'h00);
    step(1, 18, 6'h00, 16'h5000, 8'hFE, 0, 0, 8'h01);
    step(1, 18, 6'h00, 16'h5000, 8'hFE, 0, 0, 8'h02);
    step(1, 18, 6'h00, 16'h5000, 8'hFE, 0, 0, 8'hFF);
    step(0, 0, 6'h00, 16'h0, 0, 0, 0, 0);
    // R6 VT strobe only on taken code 12
    step(1, 12, 6'h02, 16'h6000, 8'h04, 0, 0, 0);
    step(1, 12, 6'h00, 16'h6000, 8'h04, 0, 0, 0);
    step(1, 13, 6'h02, 16'h6000, 8'h04, 0, 0, 0);
    // R9 wrap at 16 bits both ways, and extreme offsets
    step(1, 4, 6'h10, 16'hFFF0, 8'h7F, 0, 0, 0);
    step(1, 4, 6'h10, 16'h0010, 8'h80, 0, 0, 0);
    step(1, 4, 6'h10, 16'h8000, 8'h00, 0, 0, 0);
    step(1, 5, 6'h10, 16'hABCD, 8'h7F, 0, 0, 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom % 32, 6'($urandom), $urandom % 65536,
           $urandom % 256, $urandom % 256, $urandom % 8, $urandom % 256);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule